// File: doc/BRIEF.md
# Miss-Merging Outstanding-Line Tracker

This block sits beside a cache and keeps track of cache lines that have missed and are waiting for memory. Each incoming miss carries a request ID and a byte address. The block reduces the address to its line address and looks that line up among the lines already waiting. If the line is already waiting, the request is appended to that line's chain. If it is not, the request opens a new chain, and the caller forwards it to memory. The block reports on the same cycle whether the line was already pending and whether the request must be forwarded.

When a line comes back from memory, the fill interface names it, and its chain becomes the one active chain. The block then sends the merged request IDs back out through a ready/valid port, oldest first, one per accepted handshake. While it drains a chain it refuses further fills. When the chain runs empty, the entry is released for reuse. Writeback responses may come back through the fill port for lines that have no chain, and they are dropped. Counters report the activity: misses, merges, fills serviced, live chain entries and the peak number of live chain entries.

Top module: `mshr_merge_table`

## Requirements
- R1: The line address is the request address with its low log2(LINE_BYTES) bits cleared. Two requests whose addresses differ only in those bits share a chain. Requests to different line addresses never share a chain. `out_addr` shows the line address of the active chain.
- R2: `req_pending` is 1 when the request's line already has a chain. `req_fwd` is 1 exactly when a request is accepted (`req_valid` and `req_ready`) and its line had no chain.
- R3: `req_ready` is 0 when the request's line has a chain holding CHAIN_DEPTH IDs, or when the line has no chain and all NUM_ENT entries are in use. A request that is not ready has no effect.
- R4: An accepted fill (`fill_valid`, `fill_ready`, `fill_wb`=0) for a line with a chain makes that chain active from the next cycle on. `fill_ready` is 0 for as long as a chain is active.
- R5: While a chain is active, `out_valid` is 1 and `out_id` is the oldest ID left in that chain. Each cycle with `out_ready`=1 removes exactly one ID. With `out_ready`=0, `out_id` holds.
- R6: When the last ID of the active chain is removed and no new ID joins it in that cycle, the entry is freed, `out_valid` drops and `fill_ready` returns to 1.
- R7: A fill with `fill_wb`=1 is accepted and ignored. It changes no chain, no output and no counter.
- R8: `cnt_miss` counts accepted requests, `cnt_merge` counts accepted requests with `req_pending`=1, and `cnt_serviced` counts fills that activate a chain.
- R9: `cnt_used` is the number of IDs held in all chains: plus one per accepted request, minus one per removed ID. `cnt_peak` is the largest value `cnt_used` has reached.
- R10: After reset no chain exists. `req_ready` and `fill_ready` are 1, `out_valid` is 0 and all counters are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Miss request present |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_id | input | ID_W | Requester tag |
| req_addr | input | ADDR_W | Byte address of the miss |
| req_pending | output | 1 | Line already has a chain |
| req_fwd | output | 1 | Accepted request opened a chain; forward it to memory |
| fill_valid | input | 1 | Line returning from memory |
| fill_ready | output | 1 | Fill can be taken (no chain active) |
| fill_addr | input | ADDR_W | Address of the returning line |
| fill_wb | input | 1 | Return is a writeback response, to be dropped |
| out_valid | output | 1 | Replayed ID available |
| out_ready | input | 1 | Consumer takes the replayed ID |
| out_id | output | ID_W | Oldest ID of the active chain |
| out_addr | output | ADDR_W | Line address of the active chain |
| cnt_miss | output | CNT_W | Accepted requests |
| cnt_merge | output | CNT_W | Accepted requests that joined a chain |
| cnt_serviced | output | CNT_W | Fills that activated a chain |
| cnt_used | output | CNT_W | IDs held now |
| cnt_peak | output | CNT_W | Peak of cnt_used |

## Verification
Directed patterns come first. Addresses that differ only in their offset bits separate a correct line mask from a mask that is too wide or too narrow. Requests to NUM_ENT+1 distinct lines and CHAIN_DEPTH+1 requests to one line reach each of the two stall conditions on its own. A fill held with `out_ready` low, with a second fill offered during the drain, shows whether order and the single active chain are enforced. Writeback returns to untracked lines show whether they are truly ignored. A long random phase follows over a few lines, with random back-pressure. It reaches merges into the chain being drained, releases in the same cycle as new requests, and slot reuse. A behavioural model compares every output every cycle.

// File: rtl/mshr_pkg.sv
package mshr_pkg;

    typedef enum logic {
        DRAIN_IDLE = 1'b0,
        DRAIN_BUSY = 1'b1
    } drain_e;

    // Per-cycle events handed to the statistics block
    typedef struct packed {
        logic push;      // request accepted into some chain
        logic pop;       // one ID replayed
        logic merged;    // accepted request joined an existing chain
        logic serviced;  // fill activated a chain
    } evt_t;

    function automatic int unsigned idx_w(int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/mshr_pick_first.sv
module mshr_pick_first #(
    parameter int unsigned N  = 4,
    parameter int unsigned IW = 2
) (
    input  logic [N-1:0]  vec,
    output logic          any,
    output logic [IW-1:0] idx
);
    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) begin
                any = 1'b1;
                idx = IW'(i);
            end
        end
    end
endmodule

// File: rtl/mshr_tag_match.sv
module mshr_tag_match #(
    parameter int unsigned N     = 4,
    parameter int unsigned TAG_W = 32
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [N-1:0]           ent_valid,
    input  logic [N-1:0][TAG_W-1:0] ent_tag,
    input  logic [TAG_W-1:0]       key,
    output logic [N-1:0]           eq
);
    for (genvar e = 0; e < N; e++) begin : g_cmp
        assign eq[e] = ent_valid[e] && (ent_tag[e] == key);
    end

    // R1: a line address is held by at most one entry
    p_single_owner_r1: assert property (@(posedge clk) disable iff (rst)
        $onehot0(eq));
endmodule

// File: rtl/mshr_chain_store.sv
module mshr_chain_store #(
    parameter int unsigned NUM_ENT     = 4,
    parameter int unsigned CHAIN_DEPTH = 4,
    parameter int unsigned ID_W        = 6,
    parameter int unsigned IW          = 2,
    parameter int unsigned CW          = 3
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          push,
    input  logic [IW-1:0]                 push_idx,
    input  logic [ID_W-1:0]               push_id,
    input  logic                          pop,
    input  logic [IW-1:0]                 pop_idx,
    output logic [NUM_ENT-1:0][CW-1:0]    count,
    output logic [NUM_ENT-1:0][ID_W-1:0]  head
);
    localparam int unsigned PW = mshr_pkg::idx_w(CHAIN_DEPTH);
    localparam logic [PW-1:0] LAST = PW'(CHAIN_DEPTH - 1);
    localparam logic [CW-1:0] FULL = CW'(CHAIN_DEPTH);

    for (genvar e = 0; e < NUM_ENT; e++) begin : g_chain
        logic [ID_W-1:0] slot [CHAIN_DEPTH];
        logic [PW-1:0]   rd_p, wr_p;
        logic [CW-1:0]   n;
        logic            do_push, do_pop;

        assign do_push = push && (push_idx == IW'(e));
        assign do_pop  = pop  && (pop_idx  == IW'(e));

        always_ff @(posedge clk) begin
            if (rst) begin
                rd_p <= '0;
                wr_p <= '0;
                n    <= '0;
            end else begin
                if (do_push) begin
                    slot[wr_p] <= push_id;
                    wr_p       <= (wr_p == LAST) ? '0 : wr_p + 1'b1;
                end
                if (do_pop) begin
                    rd_p <= (rd_p == LAST) ? '0 : rd_p + 1'b1;
                end
                n <= n + CW'(do_push) - CW'(do_pop);
            end
        end

        assign count[e] = n;
        assign head[e]  = slot[rd_p];

        // R3: no chain takes an ID beyond its depth
        p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
            do_push |-> (n != FULL || do_pop));
        // R5: an empty chain is never read
        p_no_empty_pop_r5: assert property (@(posedge clk) disable iff (rst)
            do_pop |-> (n != '0));
    end
endmodule

// File: rtl/mshr_stats.sv
module mshr_stats #(
    parameter int unsigned CNT_W = 16,
    parameter int unsigned UW    = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  mshr_pkg::evt_t   ev,
    output logic [CNT_W-1:0] cnt_miss,
    output logic [CNT_W-1:0] cnt_merge,
    output logic [CNT_W-1:0] cnt_serviced,
    output logic [CNT_W-1:0] cnt_used,
    output logic [CNT_W-1:0] cnt_peak
);
    logic [UW-1:0] used_q, peak_q, used_d;

    assign used_d = used_q + UW'(ev.push) - UW'(ev.pop);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_miss     <= '0;
            cnt_merge    <= '0;
            cnt_serviced <= '0;
            used_q       <= '0;
            peak_q       <= '0;
        end else begin
            cnt_miss     <= cnt_miss + CNT_W'(ev.push);
            cnt_merge    <= cnt_merge + CNT_W'(ev.push && ev.merged);
            cnt_serviced <= cnt_serviced + CNT_W'(ev.serviced);
            used_q       <= used_d;
            if (used_d > peak_q) peak_q <= used_d;
        end
    end

    assign cnt_used = CNT_W'(used_q);
    assign cnt_peak = CNT_W'(peak_q);

    // R9: the live count never goes below zero
    p_no_underflow_r9: assert property (@(posedge clk) disable iff (rst)
        (ev.pop && !ev.push) |-> (used_q != '0));
    // R9: the peak never trails the live count
    p_peak_bound_r9: assert property (@(posedge clk) disable iff (rst)
        peak_q >= used_q);
endmodule

// File: rtl/mshr_merge_table.sv
module mshr_merge_table #(
    parameter int unsigned ADDR_W      = 32,
    parameter int unsigned ID_W        = 6,
    parameter int unsigned LINE_BYTES  = 64,
    parameter int unsigned NUM_ENT     = 4,
    parameter int unsigned CHAIN_DEPTH = 4,
    parameter int unsigned CNT_W       = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ID_W-1:0]   req_id,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              req_pending,
    output logic              req_fwd,
    input  logic              fill_valid,
    output logic              fill_ready,
    input  logic [ADDR_W-1:0] fill_addr,
    input  logic              fill_wb,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [ID_W-1:0]   out_id,
    output logic [ADDR_W-1:0] out_addr,
    output logic [CNT_W-1:0]  cnt_miss,
    output logic [CNT_W-1:0]  cnt_merge,
    output logic [CNT_W-1:0]  cnt_serviced,
    output logic [CNT_W-1:0]  cnt_used,
    output logic [CNT_W-1:0]  cnt_peak
);
    import mshr_pkg::*;

    localparam int unsigned IW = idx_w(NUM_ENT);
    localparam int unsigned CW = $clog2(CHAIN_DEPTH + 1);
    localparam int unsigned UW = $clog2(NUM_ENT * CHAIN_DEPTH + 1);
    localparam logic [ADDR_W-1:0] LINE_MASK = ~(ADDR_W'(LINE_BYTES - 1));
    localparam logic [CW-1:0] FULL = CW'(CHAIN_DEPTH);

    // Entry table
    logic [NUM_ENT-1:0]             ent_valid;
    logic [NUM_ENT-1:0][ADDR_W-1:0] ent_line;
    drain_e                         drain_q;
    logic [IW-1:0]                  act_idx;

    logic [ADDR_W-1:0] req_line, fill_line;
    logic [NUM_ENT-1:0] req_eq, fill_eq;
    logic req_hit, fill_hit, free_any;
    logic [IW-1:0] req_idx, fill_idx, free_idx;

    logic [NUM_ENT-1:0][CW-1:0]   chain_cnt;
    logic [NUM_ENT-1:0][ID_W-1:0] chain_head;

    logic push, pop, activate, release_act;
    logic [IW-1:0] push_idx;
    evt_t ev;

    assign req_line  = req_addr & LINE_MASK;
    assign fill_line = fill_addr & LINE_MASK;

    mshr_tag_match #(.N(NUM_ENT), .TAG_W(ADDR_W)) u_req_match (
        .clk(clk), .rst(rst), .ent_valid(ent_valid), .ent_tag(ent_line),
        .key(req_line), .eq(req_eq));

    mshr_tag_match #(.N(NUM_ENT), .TAG_W(ADDR_W)) u_fill_match (
        .clk(clk), .rst(rst), .ent_valid(ent_valid), .ent_tag(ent_line),
        .key(fill_line), .eq(fill_eq));

    mshr_pick_first #(.N(NUM_ENT), .IW(IW)) u_req_enc (
        .vec(req_eq), .any(req_hit), .idx(req_idx));

    mshr_pick_first #(.N(NUM_ENT), .IW(IW)) u_fill_enc (
        .vec(fill_eq), .any(fill_hit), .idx(fill_idx));

    mshr_pick_first #(.N(NUM_ENT), .IW(IW)) u_free_enc (
        .vec(~ent_valid), .any(free_any), .idx(free_idx));

    // Request side
    assign req_ready   = req_hit ? (chain_cnt[req_idx] != FULL) : free_any;
    assign req_pending = req_hit;
    assign push        = req_valid && req_ready;
    assign req_fwd     = push && !req_hit;
    assign push_idx    = req_hit ? req_idx : free_idx;

    // Fill side
    assign fill_ready = (drain_q == DRAIN_IDLE);
    assign activate   = fill_valid && fill_ready && !fill_wb && fill_hit;

    // Replay side
    assign out_valid   = (drain_q == DRAIN_BUSY);
    assign out_id      = chain_head[act_idx];
    assign out_addr    = ent_line[act_idx];
    assign pop         = out_valid && out_ready;
    assign release_act = pop && (chain_cnt[act_idx] == CW'(1))
                         && !(push && push_idx == act_idx);

    always_ff @(posedge clk) begin
        if (rst) begin
            ent_valid <= '0;
            ent_line  <= '0;
            drain_q   <= DRAIN_IDLE;
            act_idx   <= '0;
        end else begin
            if (push && !req_hit) begin
                ent_valid[free_idx] <= 1'b1;
                ent_line[free_idx]  <= req_line;
            end
            if (release_act) begin
                ent_valid[act_idx] <= 1'b0;
                drain_q            <= DRAIN_IDLE;
            end
            if (activate) begin
                drain_q <= DRAIN_BUSY;
                act_idx <= fill_idx;
            end
        end
    end

    mshr_chain_store #(
        .NUM_ENT(NUM_ENT), .CHAIN_DEPTH(CHAIN_DEPTH), .ID_W(ID_W),
        .IW(IW), .CW(CW)
    ) u_chains (
        .clk(clk), .rst(rst),
        .push(push), .push_idx(push_idx), .push_id(req_id),
        .pop(pop), .pop_idx(act_idx),
        .count(chain_cnt), .head(chain_head));

    assign ev.push     = push;
    assign ev.pop      = pop;
    assign ev.merged   = req_hit;
    assign ev.serviced = activate;

    mshr_stats #(.CNT_W(CNT_W), .UW(UW)) u_stats (
        .clk(clk), .rst(rst), .ev(ev),
        .cnt_miss(cnt_miss), .cnt_merge(cnt_merge), .cnt_serviced(cnt_serviced),
        .cnt_used(cnt_used), .cnt_peak(cnt_peak));

    // R7: a data return must find its chain; only writeback returns may miss
    p_fill_known_r7: assert property (@(posedge clk) disable iff (rst)
        (fill_valid && fill_ready && !fill_wb) |-> fill_hit);
    // R6: the active chain is never empty
    p_active_nonempty_r6: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (chain_cnt[act_idx] != '0));
    // R5: a stalled replay holds its ID
    p_hold_replay_r5: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_id)));
    // R4: the active entry stays allocated while draining
    p_active_alloc_r4: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> ent_valid[act_idx]);
endmodule

// File: tb/sim_mshr_merge_table.sv
module sim_mshr_merge_table;
    localparam int AW = 32, IDW = 6, LB = 64, NE = 4, DEP = 4, CW = 16;

    logic clk = 1'b0, rst = 1'b1;
    logic req_valid = 0, fill_valid = 0, fill_wb = 0, out_ready = 0;
    logic [IDW-1:0] req_id = '0;
    logic [AW-1:0] req_addr = '0, fill_addr = '0;
    logic req_ready, req_pending, req_fwd, fill_ready, out_valid;
    logic [IDW-1:0] out_id;
    logic [AW-1:0] out_addr;
    logic [CW-1:0] cnt_miss, cnt_merge, cnt_serviced, cnt_used, cnt_peak;

    mshr_merge_table #(.ADDR_W(AW), .ID_W(IDW), .LINE_BYTES(LB), .NUM_ENT(NE),
                       .CHAIN_DEPTH(DEP), .CNT_W(CW)) u0 (.*);

    always #4 clk = ~clk;

    int checks = 0, errors = 0;
    bit finished = 0;

    // Behavioural model
    bit          mv [NE];
    int unsigned mline [NE];
    int          mq [NE][$];
    bit          mact;
    int          mai;
    int          e_miss, e_merge, e_serv, e_used, e_peak;

    function automatic int unsigned line_of(logic [AW-1:0] a);
        return int'(a) & ~(LB - 1);
    endfunction

    function automatic int find(int unsigned ln);
        for (int i = 0; i < NE; i++) if (mv[i] && mline[i] == ln) return i;
        return -1;
    endfunction

    function automatic int first_free();
        for (int i = 0; i < NE; i++) if (!mv[i]) return i;
        return -1;
    endfunction

    task automatic chk(bit ok, string rq, string what, longint act, longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    // Compare at mid-cycle, then advance the model across the next edge
    task automatic tick();
        int m, f, fr;
        bit exp_ready, acc;
        #1;
        m  = find(line_of(req_addr));
        fr = first_free();
        exp_ready = (m >= 0) ? (mq[m].size() < DEP) : (fr >= 0);
        chk(req_ready == exp_ready, "R3", "req_ready", req_ready, exp_ready);
        if (req_valid) begin
            chk(req_pending == (m >= 0), "R2", "req_pending", req_pending, m >= 0);
            chk(req_fwd == (exp_ready && m < 0), "R2", "req_fwd", req_fwd, exp_ready && m < 0);
        end
        chk(fill_ready == !mact, "R4", "fill_ready", fill_ready, !mact);
        chk(out_valid == mact, "R6", "out_valid", out_valid, mact);
        if (mact && out_valid) begin
            chk(out_id == IDW'(mq[mai][0]), "R5", "out_id", out_id, mq[mai][0]);
            chk(out_addr == AW'(mline[mai]), "R1", "out_addr", out_addr, mline[mai]);
        end
        chk(cnt_miss == CW'(e_miss), "R8", "cnt_miss", cnt_miss, e_miss);
        chk(cnt_merge == CW'(e_merge), "R8", "cnt_merge", cnt_merge, e_merge);
        chk(cnt_serviced == CW'(e_serv), "R8", "cnt_serviced", cnt_serviced, e_serv);
        chk(cnt_used == CW'(e_used), "R9", "cnt_used", cnt_used, e_used);
        chk(cnt_peak == CW'(e_peak), "R9", "cnt_peak", cnt_peak, e_peak);

        f = find(line_of(fill_addr));
        acc = req_valid && exp_ready;
        if (mact && out_ready) begin
            void'(mq[mai].pop_front());
            e_used--;
        end
        if (acc) begin
            if (m < 0) begin
                m = fr; mv[m] = 1; mline[m] = line_of(req_addr);
            end else e_merge++;
            mq[m].push_back(int'(req_id));
            e_miss++; e_used++;
        end
        if (e_used > e_peak) e_peak = e_used;
        if (mact && mq[mai].size() == 0) begin
            mv[mai] = 0; mact = 0;
        end else if (!mact && fill_valid && !fill_wb && f >= 0) begin
            mact = 1; mai = f; e_serv++;
        end
        @(negedge clk);
    endtask

    task automatic idle_all();
        req_valid = 0; fill_valid = 0; fill_wb = 0;
    endtask

    task automatic send_req(int id, int unsigned a);
        req_valid = 1; req_id = IDW'(id); req_addr = AW'(a);
        tick();
        req_valid = 0;
    endtask

    task automatic send_fill(int unsigned a, bit wb);
        fill_valid = 1; fill_addr = AW'(a); fill_wb = wb;
        tick();
        fill_valid = 0; fill_wb = 0;
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin : main
        int k;
        for (int i = 0; i < NE; i++) mv[i] = 0;
        mact = 0; mai = 0;
        e_miss = 0; e_merge = 0; e_serv = 0; e_used = 0; e_peak = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        // R10: reset state
        #1;
        chk(req_ready && fill_ready && !out_valid, "R10", "idle flags",
            {req_ready, fill_ready, out_valid}, 3'b110);
        chk(cnt_miss == 0 && cnt_peak == 0, "R10", "counters", cnt_miss | cnt_peak, 0);
        @(negedge clk);

        // R1/R2: same line via offset bits merges, different line opens a chain
        send_req(1, 32'h1000);
        send_req(2, 32'h103C);
        send_req(3, 32'h1040);
        tick();
        // R4/R5: fill with back-pressure, second fill offered while active
        out_ready = 0;
        send_fill(32'h1008, 0);
        tick(); tick();
        send_fill(32'h1040, 0);
        out_ready = 1;
        tick(); tick(); tick();
        // R7: writeback returns for untracked lines are dropped
        send_fill(32'hF000_0000, 1);
        send_fill(32'hF000_0040, 1);
        tick();
        // R3: entries exhausted
        send_req(4, 32'h2000);
        send_req(5, 32'h3000);
        send_req(6, 32'h4000);
        send_req(7, 32'h5000);
        // R3: chain depth exhausted
        send_req(8, 32'h2004);
        send_req(9, 32'h2008);
        send_req(10, 32'h200C);
        send_req(11, 32'h2010);
        // R6: drain every line, entries freed
        send_fill(32'h1040, 0); repeat (3) tick();
        send_fill(32'h2000, 0); repeat (6) tick();
        send_fill(32'h3000, 0); repeat (3) tick();
        send_fill(32'h4000, 0); repeat (3) tick();
        send_req(12, 32'h5000);
        tick();

        // Random phase: few lines, merges into the draining chain, back-pressure
        for (int c = 0; c < 6000; c++) begin
            req_valid = ($urandom_range(0, 99) < 45);
            req_id    = IDW'($urandom);
            req_addr  = AW'(32'h8000 + $urandom_range(0, 5) * LB + $urandom_range(0, LB - 1));
            out_ready = ($urandom_range(0, 99) < 60);
            fill_valid = 0; fill_wb = 0;
            if ($urandom_range(0, 99) < 30) begin
                k = $urandom_range(0, NE - 1);
                fill_valid = 1;
                if (mv[k] && $urandom_range(0, 3) != 0) begin
                    fill_addr = AW'(mline[k] + $urandom_range(0, LB - 1));
                end else begin
                    fill_wb = 1;
                    fill_addr = AW'(32'hF000_0000 + $urandom_range(0, 255) * LB);
                end
            end
            tick();
        end
        idle_all();
        out_ready = 1;
        repeat (20) tick();

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule